// File: doc/BRIEF.md
# Masked Trigger Decision with Random Prescaling

This block turns trigger words from peak search into a set of output trigger bits. Four 16-bit trigger words arrive together, one from each peak search source, marked by a valid strobe. Each output bit picks one of the four words with its own 2-bit source selector. It then checks that word against its own require mask and veto mask. A bit that passes both checks and is enabled becomes a candidate. The candidate is then thinned by a pseudo-random draw set by a 16-bit prescale value.

Each output bit owns a free-running 32-bit linear feedback shift register. Every bit starts from a different seed. Each register moves sixteen steps per clock, so successive draws share no bits. The draw is the upper 16 bits of the register. A candidate is accepted when the draw is less than or equal to its prescale value P, which gives an acceptance rate of (P+1)/65536.

The outputs are registered and appear one cycle after a valid word. Both the candidate vector and the final trigger vector are available, so the mask logic can be observed apart from the random thinning.

Top module: `trig_decide`

## Requirements
- R1: While reset is asserted, and after it, until the first valid word, trigOut, candOut and outValid are all 0.
- R2: Inputs sampled on a clock edge with wordValid high appear on candOut and trigOut after that edge, with outValid 1. After an edge with wordValid low, candOut, trigOut and outValid are all 0.
- R3: Output bit i can be a candidate only when every bit set in its require mask (requireMasks[16i+15:16i]) is 1 in its selected word.
- R4: Output bit i can be a candidate only when every bit set in its veto mask (vetoMasks[16i+15:16i]) is 0 in its selected word.
- R5: The selector of output bit i, srcSel[2i+1:2i] = k, selects trigger word k, which is trigWords[16k+15:16k].
- R6: When enableMask[i] is 0, candOut[i] and trigOut[i] are 0 whatever the words and masks are.
- R7: trigOut[i] is 1 only when candOut[i] is 1 in the same cycle.
- R8: A prescale value of 0xFFFF in prescale[16i+15:16i] accepts every candidate, so trigOut[i] equals candOut[i].
- R9: Over many candidates, the fraction accepted is (P+1)/65536. With P = 0x0000, at most a handful out of tens of thousands are accepted.
- R10: The output bits draw independently. With equal prescale values and candidates on every cycle, two bits disagree on a large share of cycles.
- R11: An output bit with empty require and veto masks is a candidate on every valid word while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | Trigger words are valid this cycle |
| trigWords | input | 64 | Four 16-bit trigger words; word k is at bits [16k+15:16k] |
| requireMasks | input | 128 | Require mask per output bit; bit i is at [16i+15:16i] |
| vetoMasks | input | 128 | Veto mask per output bit; bit i is at [16i+15:16i] |
| srcSel | input | 16 | 2-bit source selector per output bit at [2i+1:2i] |
| enableMask | input | 8 | Per-bit enable |
| prescale | input | 128 | 16-bit prescale value P per output bit at [16i+15:16i] |
| trigOut | output | 8 | Accepted trigger bits, registered |
| candOut | output | 8 | Mask-qualified candidates before prescaling, registered |
| outValid | output | 1 | Registered copy of wordValid |

## Verification
The hardest behaviour to reach from the ports is the random thinning. A rate of (P+1)/65536 only shows over many draws, and the rare-accept end of the range (P = 0) almost never fires. The stimulus holds wordValid high for thousands of cycles with empty masks and all bits enabled, so every draw is a candidate. It then counts accepts across all eight bits for several values of P and also counts how often two bits disagree. Random sparse masks with a mix of 0xFFFF and random prescale values exercise the mask checks, with both met and unmet conditions.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int LFSR_W = 32;
  // Galois form of x^32 + x^22 + x^2 + x + 1
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

  typedef struct packed {
    logic capture;  // register the evaluated decision
    logic flush;    // clear the output registers
    logic advance;  // step the random sources
  } ctrlStrobe_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ LFSR_TAPS;
    return n;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsrSeed(input int unsigned idx);
    logic [LFSR_W-1:0] v;
    v = 32'hACE1_5EED ^ (LFSR_W'(idx + 1) * 32'h9E37_79B9);
    if (v == '0) v = 32'h0000_0001;
    return v;
  endfunction

endpackage

// File: rtl/trigCtrl.sv
module trigCtrl
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.capture = wordValid;
    strobe.flush   = ~wordValid;
    strobe.advance = rstN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= wordValid;
  end

endmodule

// File: rtl/prngBank.sv
module prngBank
  import trig_pkg::*;
#(
  parameter int NUM_OUT    = 8,
  parameter int DRAW_W     = 16,
  parameter int STEPS      = 16,
  localparam int DRAWS_W   = NUM_OUT * DRAW_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  output logic [DRAWS_W-1:0] draws
);

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : gSrc
      localparam logic [LFSR_W-1:0] SEED = lfsrSeed(g);
      logic [LFSR_W-1:0] state;
      logic [LFSR_W-1:0] stateNext;

      always_comb begin
        stateNext = state;
        for (int k = 0; k < STEPS; k++) stateNext = lfsrStep(stateNext);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               state <= SEED;
        else if (strobe.advance) state <= stateNext;
      end

      assign draws[g*DRAW_W +: DRAW_W] = state[LFSR_W-1 -: DRAW_W];
    end
  endgenerate

endmodule

// File: rtl/trigDatapath.sv
module trigDatapath
  import trig_pkg::*;
#(
  parameter int NUM_OUT    = 8,
  parameter int NUM_SRC    = 4,
  parameter int WORD_W     = 16,
  parameter int PRESCALE_W = 16,
  localparam int SEL_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int WORDS_W   = NUM_SRC * WORD_W,
  localparam int MASKS_W   = NUM_OUT * WORD_W,
  localparam int SELS_W    = NUM_OUT * SEL_W,
  localparam int PS_W      = NUM_OUT * PRESCALE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [WORDS_W-1:0] trigWords,
  input  logic [MASKS_W-1:0] requireMasks,
  input  logic [MASKS_W-1:0] vetoMasks,
  input  logic [SELS_W-1:0]  srcSel,
  input  logic [NUM_OUT-1:0] enableMask,
  input  logic [PS_W-1:0]    prescale,
  input  logic [PS_W-1:0]    draws,
  output logic [NUM_OUT-1:0] trigOut,
  output logic [NUM_OUT-1:0] candOut
);

  logic [WORD_W-1:0]  srcWord [NUM_SRC];
  logic [NUM_OUT-1:0] candNext;
  logic [NUM_OUT-1:0] acceptNext;

  genvar s, g;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : gWord
      assign srcWord[s] = trigWords[s*WORD_W +: WORD_W];
    end

    for (g = 0; g < NUM_OUT; g++) begin : gBit
      logic [SEL_W-1:0]      selG;
      logic [WORD_W-1:0]     picked;
      logic [WORD_W-1:0]     reqG;
      logic [WORD_W-1:0]     vetoG;
      logic [PRESCALE_W-1:0] limitG;
      logic [PRESCALE_W-1:0] drawG;
      logic                  reqMet;
      logic                  vetoClear;
      logic                  drawWins;

      assign selG      = srcSel[g*SEL_W +: SEL_W];
      assign picked    = srcWord[selG];
      assign reqG      = requireMasks[g*WORD_W +: WORD_W];
      assign vetoG     = vetoMasks[g*WORD_W +: WORD_W];
      assign limitG    = prescale[g*PRESCALE_W +: PRESCALE_W];
      assign drawG     = draws[g*PRESCALE_W +: PRESCALE_W];
      assign reqMet    = ((picked & reqG) == reqG);
      assign vetoClear = ((picked & vetoG) == '0);
      assign drawWins  = (drawG <= limitG);

      assign candNext[g]   = enableMask[g] & reqMet & vetoClear;
      assign acceptNext[g] = candNext[g] & drawWins;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candOut <= '0;
      trigOut <= '0;
    end else if (strobe.capture) begin
      candOut <= candNext;
      trigOut <= acceptNext;
    end else if (strobe.flush) begin
      candOut <= '0;
      trigOut <= '0;
    end
  end

endmodule

// File: rtl/trig_decide.sv
module trig_decide
  import trig_pkg::*;
#(
  parameter int NUM_OUT    = 8,
  parameter int NUM_SRC    = 4,
  parameter int WORD_W     = 16,
  parameter int PRESCALE_W = 16,
  parameter int LFSR_STEPS = 16,
  localparam int SEL_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int WORDS_W   = NUM_SRC * WORD_W,
  localparam int MASKS_W   = NUM_OUT * WORD_W,
  localparam int SELS_W    = NUM_OUT * SEL_W,
  localparam int PS_W      = NUM_OUT * PRESCALE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordValid,
  input  logic [WORDS_W-1:0] trigWords,
  input  logic [MASKS_W-1:0] requireMasks,
  input  logic [MASKS_W-1:0] vetoMasks,
  input  logic [SELS_W-1:0]  srcSel,
  input  logic [NUM_OUT-1:0] enableMask,
  input  logic [PS_W-1:0]    prescale,
  output logic [NUM_OUT-1:0] trigOut,
  output logic [NUM_OUT-1:0] candOut,
  output logic               outValid
);

  ctrlStrobe_t     strobe;
  logic [PS_W-1:0] draws;

  trigCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  prngBank #(
    .NUM_OUT (NUM_OUT),
    .DRAW_W  (PRESCALE_W),
    .STEPS   (LFSR_STEPS)
  ) u_prng (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .draws  (draws)
  );

  trigDatapath #(
    .NUM_OUT    (NUM_OUT),
    .NUM_SRC    (NUM_SRC),
    .WORD_W     (WORD_W),
    .PRESCALE_W (PRESCALE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .trigWords    (trigWords),
    .requireMasks (requireMasks),
    .vetoMasks    (vetoMasks),
    .srcSel       (srcSel),
    .enableMask   (enableMask),
    .prescale     (prescale),
    .draws        (draws),
    .trigOut      (trigOut),
    .candOut      (candOut)
  );

endmodule

// File: rtl/trig_decide_chk.sv
module trig_decide_chk #(
  parameter int NUM_OUT    = 8,
  parameter int PRESCALE_W = 16,
  localparam int PS_W      = NUM_OUT * PRESCALE_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               wordValid,
  input logic [NUM_OUT-1:0] enableMask,
  input logic [PS_W-1:0]    prescale,
  input logic [NUM_OUT-1:0] trigOut,
  input logic [NUM_OUT-1:0] candOut,
  input logic               outValid
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(wordValid)));

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wordValid)) |-> ((trigOut == '0) && (candOut == '0)));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((trigOut | candOut) & ~$past(enableMask)) == '0));

  // R7
  accept_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((trigOut & ~candOut) == '0));

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : gFull
      // R8
      full_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && ($past(prescale[g*PRESCALE_W +: PRESCALE_W]) == '1))
          |-> (trigOut[g] == candOut[g]));
    end
  endgenerate

endmodule

bind trig_decide trig_decide_chk #(
  .NUM_OUT    (NUM_OUT),
  .PRESCALE_W (PRESCALE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wordValid  (wordValid),
  .enableMask (enableMask),
  .prescale   (prescale),
  .trigOut    (trigOut),
  .candOut    (candOut),
  .outValid   (outValid)
);

// File: tb/trig_decide_tb.sv
`timescale 1ns/1ps
module trig_decide_tb;

  localparam int NO = 8;
  localparam int NS = 4;
  localparam int WW = 16;
  localparam int STAT_N = 4000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wordValid = 1'b0;
  logic [NS*WW-1:0] words = '0;
  logic [NO*WW-1:0] reqM = '0;
  logic [NO*WW-1:0] vetoM = '0;
  logic [NO*2-1:0]  sel = '0;
  logic [NO-1:0]    en = '0;
  logic [NO*WW-1:0] ps = '0;
  logic [NO-1:0]    trigOut, candOut;
  logic             outValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  trig_decide u_dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .trigWords(words),
    .requireMasks(reqM), .vetoMasks(vetoM), .srcSel(sel), .enableMask(en),
    .prescale(ps), .trigOut(trigOut), .candOut(candOut), .outValid(outValid)
  );

  function automatic logic [NO-1:0] expCand(
      input logic [NS*WW-1:0] w, input logic [NO*WW-1:0] rq,
      input logic [NO*WW-1:0] vt, input logic [NO*2-1:0] sl, input logic [NO-1:0] e);
    logic [NO-1:0] r;
    for (int i = 0; i < NO; i++) begin
      logic [WW-1:0] pw;
      logic [WW-1:0] rm;
      logic [WW-1:0] vm;
      int k;
      k  = int'(sl[2*i +: 2]);
      pw = w[k*WW +: WW];
      rm = rq[i*WW +: WW];
      vm = vt[i*WW +: WW];
      r[i] = e[i];
      for (int b = 0; b < WW; b++) begin
        if (rm[b] && !pw[b]) r[i] = 1'b0;
        if (vm[b] && pw[b])  r[i] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // Drive inputs at a negedge, sample registered outputs at the next negedge
  task automatic applyCheck(input string tag);
    logic [NO-1:0] ec;
    logic [NO-1:0] fullMask;
    ec = expCand(words, reqM, vetoM, sel, en);
    fullMask = '0;
    for (int i = 0; i < NO; i++) fullMask[i] = (ps[i*WW +: WW] == 16'hFFFF);
    wordValid = 1'b1;
    @(negedge clk);
    check(candOut == ec, tag, candOut, ec);
    check((trigOut & ~candOut) == '0, "R7", trigOut, candOut);
    check((trigOut & fullMask) == (candOut & fullMask), "R8", trigOut & fullMask, candOut & fullMask);
    check(outValid == 1'b1, "R2", outValid, 1);
  endtask

  task automatic setAll(input logic [WW-1:0] rq, input logic [WW-1:0] vt,
                        input logic [1:0] s, input logic [WW-1:0] p);
    for (int i = 0; i < NO; i++) begin
      reqM[i*WW +: WW] = rq;
      vetoM[i*WW +: WW] = vt;
      sel[2*i +: 2] = s;
      ps[i*WW +: WW] = p;
    end
  endtask

  task automatic rateRun(input logic [WW-1:0] p, input int tol);
    int acc;
    int diff;
    longint expAcc;
    int total;
    total = STAT_N * NO;
    setAll(16'h0000, 16'h0000, 2'd0, p);
    en = '1;
    wordValid = 1'b1;
    acc = 0;
    diff = 0;
    for (int n = 0; n < STAT_N; n++) begin
      @(negedge clk);
      acc += $countones(trigOut);
      if (trigOut[0] != trigOut[1]) diff++;
      if (n == 0) check(candOut == '1, "R11", candOut, 8'hFF);
    end
    expAcc = (longint'(p) + 1) * total / 65536;
    check((acc >= expAcc - tol) && (acc <= expAcc + tol), "R9", acc, expAcc);
    if (p == 16'h7FFF) check(diff >= STAT_N / 4, "R10", diff, STAT_N / 2);
  endtask

  initial begin
    #1_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({trigOut, candOut, outValid} == '0, "R1", {trigOut, candOut, outValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({trigOut, candOut, outValid} == '0, "R1", {trigOut, candOut, outValid}, 0);

    // R3 directed: require bits 0 and 2 on word 0
    en = '1;
    setAll(16'h0000, 16'h0000, 2'd0, 16'hFFFF);
    reqM[WW-1:0] = 16'h0005;
    words = {16'h0, 16'h0, 16'h0, 16'h0004};
    applyCheck("R3");
    check(candOut[0] == 1'b0, "R3", candOut[0], 0);
    words[WW-1:0] = 16'h0005;
    applyCheck("R3");
    check(trigOut[0] == 1'b1, "R3", trigOut[0], 1);

    // R4 directed: veto bit 15 hit
    vetoM[WW-1:0] = 16'h8000;
    words[WW-1:0] = 16'h8005;
    applyCheck("R4");
    check(candOut[0] == 1'b0, "R4", candOut[0], 0);

    // R5 directed: each bit needs a marker present only in its selected word
    setAll(16'h0000, 16'h0000, 2'd0, 16'hFFFF);
    words = {16'h0008, 16'h0004, 16'h0002, 16'h0001};
    for (int i = 0; i < NO; i++) begin
      reqM[i*WW +: WW] = 16'h1 << (i % 4);
      sel[2*i +: 2] = (i < 4) ? 2'(i) : 2'((i + 1) % 4);
    end
    applyCheck("R5");
    check(candOut == 8'h0F, "R5", candOut, 8'h0F);

    // R6 directed: disabled bits stay low with empty masks
    setAll(16'h0000, 16'h0000, 2'd1, 16'hFFFF);
    en = 8'b1010_0101;
    applyCheck("R6");
    check(trigOut == 8'b1010_0101, "R6", trigOut, 8'hA5);
    en = '0;
    applyCheck("R6");
    check(trigOut == '0, "R6", trigOut, 0);

    // R2: idle cycle clears outputs
    en = '1;
    wordValid = 1'b0;
    @(negedge clk);
    check({trigOut, candOut, outValid} == '0, "R2", {trigOut, candOut, outValid}, 0);

    // Random mask patterns
    for (int t = 0; t < 300; t++) begin
      words = {$urandom, $urandom};
      for (int i = 0; i < NO; i++) begin
        reqM[i*WW +: WW]  = WW'($urandom & $urandom & $urandom);
        vetoM[i*WW +: WW] = WW'($urandom & $urandom & $urandom);
        sel[2*i +: 2]     = 2'($urandom);
        en[i]             = ($urandom % 4) != 0;
        ps[i*WW +: WW]    = ($urandom % 2) ? 16'hFFFF : WW'($urandom);
      end
      applyCheck("R3/R4 random");
    end

    // Statistical rates
    rateRun(16'h7FFF, 800);
    rateRun(16'h3FFF, 700);
    rateRun(16'hBFFF, 700);
    rateRun(16'h0000, 5);

    wordValid = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule